// File: doc/BRIEF.md
# Three-Wire Sensor Register Master

This block drives a small sensor over a three-wire link: a serial clock, one data line shared by both directions, and an active-low select. A host issues one of four commands: a single register read, a single register write, a two-byte motion burst, or a select resync pulse. The block then runs the whole transaction, including bit timing, the turnaround of the shared data line and the pauses between bytes. All intervals are whole multiples of a microsecond. A microsecond is `TICK_CYC` system clock cycles.

The data line leaves the block as a value plus an output enable, so the tristate pad can be placed at the chip top. Commands use a valid/ready handshake. `cmd_ready` is low for the whole transaction, so a command presented during that time is held off and has no effect. Results are not back-pressured. The block pulses `rsp_valid` for one cycle when a transaction ends. `rsp_byte0` and `rsp_byte1` are meaningful only in that cycle, and the host must capture them then.

Top module: `twl_reg_master`

## Requirements
- R1: After reset and whenever no transaction runs, `csn_o` is 1, `sck_o` is 1, `sdio_oe` is 0, `sdio_o` is 0, `busy` is 0 and `cmd_ready` is 1.
- R2: Every byte sent goes out most significant bit first. Each bit holds `sck_o` low for `TXLO_US` µs (default 2) with the bit on `sdio_o`, then holds `sck_o` high for `TXHI_US` µs (default 1) with the bit unchanged.
- R3: Every byte received comes in most significant bit first. Each bit holds `sck_o` low for `RX_US` µs (default 1), samples `sdio_i` at the end of that low phase, then holds `sck_o` high for `RX_US` µs.
- R4: After every byte sent, the block holds `sck_o` high with the output disabled for `GAP_US` µs (default 4). Select stays low during this gap.
- R5: `cmd_op` = 1 (write) sends the address with bit 7 set to 1, then sends `cmd_wdata`, all within one low period of `csn_o`.
- R6: `cmd_op` = 0 (read) sends the address with bit 7 at 0 and receives one byte. It then waits `TAIL_US` µs (default 1) before raising `csn_o`. The received byte appears on `rsp_byte0`, and `rsp_byte1` is 0.
- R7: `cmd_op` = 2 (burst) sends `BURST_ADDR` (default 0x50) with bit 7 at 0 and receives exactly two bytes. It raises `csn_o` at once after the second byte. The first byte (delta X) appears on `rsp_byte0` and the second (delta Y) on `rsp_byte1`.
- R8: `cmd_op` = 3 (resync) drives `csn_o` low for `SYNC_US` µs (default 1) with `sck_o` high and no data movement.
- R9: `sdio_oe` is 1 only while sent bits are on the line. It is 0 during gaps, during reception and during the tail.
- R10: A command is accepted only on a cycle where `cmd_valid` and `cmd_ready` are both 1. While `busy` is 1, `cmd_ready` is 0 and `cmd_valid` changes nothing.
- R11: `rsp_valid` is high for exactly one cycle. That cycle is the first idle cycle after a transaction, and in it `busy` has already fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_op | input | 2 | 0 read, 1 write, 2 burst, 3 resync |
| cmd_addr | input | DW-1 | Register address |
| cmd_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle done strobe |
| rsp_byte0 | output | DW | Read byte, or burst delta X |
| rsp_byte1 | output | DW | Burst delta Y, else 0 |
| busy | output | 1 | Transaction in progress |
| sck_o | output | 1 | Serial clock, idles high |
| csn_o | output | 1 | Active-low select |
| sdio_o | output | 1 | Data line value to pad |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line value from pad |

## Verification
The pins change in the cycle right after the accepting edge, because they are decoded from registered state. Every later phase then lasts exactly its microsecond count times `TICK_CYC` cycles. `rsp_valid` and the result bytes arrive in the first cycle after the last phase. For a burst this is the cycle after the final high half-bit, and for a read it comes one tail interval later. On each accepting edge, the bench's reference model queues one expected pin vector per cycle. It pops and compares one vector at every falling clock edge, so each comparison falls in the exact cycle the requirement names. It checks the data bytes in the strobe cycle.

// File: rtl/twl_pkg.sv
package twl_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_BURST  = 2'd2,
    OP_RESYNC = 2'd3
  } twl_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TXLO, ST_TXHI, ST_GAP, ST_RXLO, ST_RXHI, ST_TAIL, ST_SYNC
  } twl_st_e;
endpackage

// File: rtl/twl_timer.sv
module twl_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/twl_shift.sv
module twl_shift #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   first_byte,
  input  logic [DW-1:0]   next_byte,
  input  logic            tx_shift,
  input  logic            tx_reload,
  input  logic            rx_shift,
  input  logic            sdi,
  output logic            tx_msb,
  output logic [2*DW-1:0] rx_word
);
  logic [DW-1:0]   tx_q;
  logic [DW-1:0]   hold_q;
  logic [2*DW-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      hold_q <= '0;
      rx_q   <= '0;
    end else begin
      if (load) begin
        tx_q   <= first_byte;
        hold_q <= next_byte;
        rx_q   <= '0;
      end else begin
        if (tx_reload)     tx_q <= hold_q;
        else if (tx_shift) tx_q <= {tx_q[DW-2:0], 1'b0};
        if (rx_shift)      rx_q <= {rx_q[2*DW-2:0], sdi};
      end
    end
  end

  assign tx_msb  = tx_q[DW-1];
  assign rx_word = rx_q;
endmodule

// File: rtl/twl_seq.sv
module twl_seq
  import twl_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TW       = 8,
  parameter int TICK_CYC = 4,
  parameter int TXLO_US  = 2,
  parameter int TXHI_US  = 1,
  parameter int GAP_US   = 4,
  parameter int RX_US    = 1,
  parameter int TAIL_US  = 1,
  parameter int SYNC_US  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_fire,
  input  twl_op_e       cmd_op,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tx_shift,
  output logic          tx_reload,
  output logic          rx_shift,
  output twl_st_e       st,
  output twl_op_e       op,
  output logic          busy,
  output logic          done
);
  localparam int CW     = $clog2(2*DW);
  localparam int V_TXLO = TXLO_US*TICK_CYC - 1;
  localparam int V_TXHI = TXHI_US*TICK_CYC - 1;
  localparam int V_GAP  = GAP_US*TICK_CYC - 1;
  localparam int V_RX   = RX_US*TICK_CYC - 1;
  localparam int V_TAIL = TAIL_US*TICK_CYC - 1;
  localparam int V_SYNC = SYNC_US*TICK_CYC - 1;

  twl_st_e       st_q, st_n;
  twl_op_e       op_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sec_q, sec_n;
  logic          done_q, done_n;
  logic          last_tx, last_rx;

  assign last_tx = (cnt_q == CW'(DW-1));
  assign last_rx = (op_q == OP_BURST) ? (cnt_q == CW'(2*DW-1)) : (cnt_q == CW'(DW-1));

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    sec_n     = sec_q;
    done_n    = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    tx_shift  = 1'b0;
    tx_reload = 1'b0;
    rx_shift  = 1'b0;
    case (st_q)
      ST_IDLE: if (cmd_fire) begin
        cnt_n    = '0;
        sec_n    = 1'b0;
        tmr_load = 1'b1;
        if (cmd_op == OP_RESYNC) begin
          st_n = ST_SYNC; tmr_val = TW'(V_SYNC);
        end else begin
          st_n = ST_TXLO; tmr_val = TW'(V_TXLO);
        end
      end
      ST_TXLO: if (tmr_zero) begin
        st_n = ST_TXHI; tmr_load = 1'b1; tmr_val = TW'(V_TXHI);
      end
      ST_TXHI: if (tmr_zero) begin
        tx_shift = 1'b1;
        tmr_load = 1'b1;
        if (last_tx) begin
          st_n = ST_GAP; tmr_val = TW'(V_GAP); cnt_n = '0;
        end else begin
          st_n = ST_TXLO; tmr_val = TW'(V_TXLO); cnt_n = cnt_q + 1'b1;
        end
      end
      ST_GAP: if (tmr_zero) begin
        if (op_q == OP_WRITE) begin
          if (!sec_q) begin
            st_n = ST_TXLO; tmr_load = 1'b1; tmr_val = TW'(V_TXLO);
            tx_reload = 1'b1; sec_n = 1'b1;
          end else begin
            st_n = ST_IDLE; done_n = 1'b1;
          end
        end else begin
          st_n = ST_RXLO; tmr_load = 1'b1; tmr_val = TW'(V_RX);
        end
      end
      ST_RXLO: if (tmr_zero) begin
        rx_shift = 1'b1;
        st_n = ST_RXHI; tmr_load = 1'b1; tmr_val = TW'(V_RX);
      end
      ST_RXHI: if (tmr_zero) begin
        if (last_rx) begin
          if (op_q == OP_READ) begin
            st_n = ST_TAIL; tmr_load = 1'b1; tmr_val = TW'(V_TAIL);
          end else begin
            st_n = ST_IDLE; done_n = 1'b1;
          end
        end else begin
          st_n = ST_RXLO; tmr_load = 1'b1; tmr_val = TW'(V_RX);
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_TAIL, ST_SYNC: if (tmr_zero) begin
        st_n = ST_IDLE; done_n = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_READ;
      cnt_q  <= '0;
      sec_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sec_q  <= sec_n;
      done_q <= done_n;
      if (cmd_fire && st_q == ST_IDLE) op_q <= cmd_op;
    end
  end

  assign st   = st_q;
  assign op   = op_q;
  assign busy = (st_q != ST_IDLE);
  assign done = done_q;

  // R10: the latched command cannot change mid-transaction
  a_r10_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(op_q));
  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/twl_reg_master.sv
module twl_reg_master
  import twl_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TICK_CYC   = 250,
  parameter int TXLO_US    = 2,
  parameter int TXHI_US    = 1,
  parameter int GAP_US     = 4,
  parameter int RX_US      = 1,
  parameter int TAIL_US    = 1,
  parameter int SYNC_US    = 1,
  parameter int BURST_ADDR = 'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [DW-2:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_byte0,
  output logic [DW-1:0] rsp_byte1,
  output logic          busy,
  output logic          sck_o,
  output logic          csn_o,
  output logic          sdio_o,
  output logic          sdio_oe,
  input  logic          sdio_i
);
  localparam int AW   = DW - 1;
  localparam int MAXC = (TXLO_US + TXHI_US + GAP_US + RX_US + TAIL_US + SYNC_US) * TICK_CYC;
  localparam int TW   = $clog2(MAXC + 1);

  twl_op_e        op_in, op_q;
  twl_st_e        st;
  logic           fire, tmr_zero, tmr_load, tx_shift, tx_reload, rx_shift, tx_msb;
  logic [TW-1:0]  tmr_val;
  logic [DW-1:0]  first_byte;
  logic [2*DW-1:0] rx_word;

  assign op_in     = twl_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign fire      = cmd_valid && !busy;

  always_comb begin
    case (op_in)
      OP_WRITE: first_byte = {1'b1, cmd_addr};
      OP_BURST: first_byte = {1'b0, AW'(BURST_ADDR)};
      default:  first_byte = {1'b0, cmd_addr};
    endcase
  end

  twl_seq #(
    .DW(DW), .TW(TW), .TICK_CYC(TICK_CYC), .TXLO_US(TXLO_US), .TXHI_US(TXHI_US),
    .GAP_US(GAP_US), .RX_US(RX_US), .TAIL_US(TAIL_US), .SYNC_US(SYNC_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_fire(fire), .cmd_op(op_in), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tx_shift(tx_shift), .tx_reload(tx_reload),
    .rx_shift(rx_shift), .st(st), .op(op_q), .busy(busy), .done(rsp_valid)
  );

  twl_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  twl_shift #(.DW(DW)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(fire), .first_byte(first_byte), .next_byte(cmd_wdata),
    .tx_shift(tx_shift), .tx_reload(tx_reload), .rx_shift(rx_shift), .sdi(sdio_i),
    .tx_msb(tx_msb), .rx_word(rx_word)
  );

  assign csn_o   = (st == ST_IDLE);
  assign sck_o   = !(st == ST_TXLO || st == ST_RXLO);
  assign sdio_oe = (st == ST_TXLO || st == ST_TXHI);
  assign sdio_o  = sdio_oe & tx_msb;

  assign rsp_byte0 = (op_q == OP_BURST) ? rx_word[2*DW-1:DW] : rx_word[DW-1:0];
  assign rsp_byte1 = (op_q == OP_BURST) ? rx_word[DW-1:0]    : '0;

  // R9: the pad is driven only inside a selected frame
  a_r9_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !csn_o);
  // R2: a sent bit does not move while the clock is high
  a_r2_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TXHI) |-> $stable(sdio_o));
  // R11: the strobe marks the end of a busy period
  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !busy));
  // R1: idle pins
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csn_o && sck_o && !sdio_oe && !sdio_o));
endmodule

// File: tb/tb_twl_reg_master.sv
module tb_twl_reg_master;
  localparam int TICK = 4;
  localparam int BADDR = 'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic sdio_i = 1'b0;
  logic cmd_ready, rsp_valid, busy, sck_o, csn_o, sdio_o, sdio_oe;
  logic [7:0] rsp_byte0, rsp_byte1;

  int checks = 0;
  int errors = 0;
  logic [15:0] pat = '0;
  int ridx = 0;
  logic [7:0] exp_b0 = '0, exp_b1 = '0;
  logic exp_chk = 1'b0;
  string exp_tag = "R6";

  logic [5:0] mq[$];
  string      tq[$];

  always #2 clk = ~clk;

  twl_reg_master #(.TICK_CYC(TICK), .BURST_ADDR(BADDR)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_byte0(rsp_byte0), .rsp_byte1(rsp_byte1),
    .busy(busy), .sck_o(sck_o), .csn_o(csn_o), .sdio_o(sdio_o),
    .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  // sensor responder: presents the next pattern bit on each falling clock
  always @(negedge sck_o or posedge csn_o) begin
    if (csn_o) ridx <= 0;
    else if (!sdio_oe) begin
      sdio_i <= pat[4'(15 - ridx)];
      ridx   <= ridx + 1;
    end
  end

  // vector {busy, done, csn, sck, oe, sdo}
  task automatic push(int n, logic [5:0] v, string tag);
    for (int i = 0; i < n; i++) begin mq.push_back(v); tq.push_back(tag); end
  endtask

  task automatic m_tx(logic [7:0] b, string tag);
    for (int i = 7; i >= 0; i--) begin
      push(2*TICK, {4'b1000, 1'b1, b[i]}, {tag, " R2 R9"});
      push(TICK,   {4'b1001, 1'b1, b[i]}, {tag, " R2 R9"});
    end
    push(4*TICK, 6'b100100, "R4 R9");
  endtask

  task automatic m_rx(int n);
    for (int i = 0; i < n; i++) begin
      push(TICK, 6'b100000, "R3 R9");
      push(TICK, 6'b100100, "R3 R9");
    end
  endtask

  // reference model: expands an accepted command into per-cycle pin vectors
  always @(posedge clk) begin
    if (rst_n && cmd_valid && mq.size() == 0) begin
      case (cmd_op)
        2'd0: begin m_tx({1'b0, cmd_addr}, "R6"); m_rx(8); push(TICK, 6'b100100, "R6"); end
        2'd1: begin m_tx({1'b1, cmd_addr}, "R5"); m_tx(cmd_wdata, "R5"); end
        2'd2: begin m_tx({1'b0, 7'(BADDR)}, "R7"); m_rx(16); end
        default: push(TICK, 6'b100100, "R8");
      endcase
      push(1, 6'b011100, "R11");
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] e, a;
      string t;
      if (mq.size() != 0) begin e = mq.pop_front(); t = tq.pop_front(); end
      else begin e = 6'b001100; t = "R1 R10"; end
      a = {busy, rsp_valid, csn_o, sck_o, sdio_oe, sdio_o};
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s pins busy/done/csn/sck/oe/sdo actual %b expected %b at %0t", t, a, e, $time);
      end
      checks++;
      if (cmd_ready !== !busy) begin
        errors++;
        $display("FAIL R10 cmd_ready actual %b expected %b", cmd_ready, !busy);
      end
      if (rsp_valid && exp_chk) begin
        checks++;
        if (rsp_byte0 !== exp_b0 || rsp_byte1 !== exp_b1) begin
          errors++;
          $display("FAIL %s bytes actual %h %h expected %h %h", exp_tag, rsp_byte0, rsp_byte1, exp_b0, exp_b1);
        end
      end
    end
  end

  task automatic issue(logic [1:0] op, logic [6:0] ad, logic [7:0] wd, logic [15:0] p,
                       logic chk, logic [7:0] b0, logic [7:0] b1, string tag);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    pat = p; exp_chk = chk; exp_b0 = b0; exp_b1 = b1; exp_tag = tag;
    cmd_op = op; cmd_addr = ad; cmd_wdata = wd; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 reset state
    if ({csn_o, sck_o, sdio_oe, sdio_o, busy, rsp_valid} !== 6'b110000) begin
      errors++;
      $display("FAIL R1 reset pins actual %b expected %b",
               {csn_o, sck_o, sdio_oe, sdio_o, busy, rsp_valid}, 6'b110000);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R5 write with bit 7 forced
    issue(2'd1, 7'h0D, 8'hA5, 16'h0000, 1'b0, 8'h00, 8'h00, "R5");
    wait_done();
    // R6 single read
    issue(2'd0, 7'h12, 8'hFF, 16'h3C00, 1'b1, 8'h3C, 8'h00, "R6");
    wait_done();
    // R7 burst, with an R10 command presented while busy
    issue(2'd2, 7'h00, 8'h00, 16'h817F, 1'b1, 8'h81, 8'h7F, "R7");
    repeat (20) @(negedge clk);
    cmd_op = 2'd1; cmd_addr = 7'h11; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    // R8 resync pulse
    issue(2'd3, 7'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, "R8");
    wait_done();
    // boundary patterns, back to back
    issue(2'd0, 7'h7F, 8'h00, 16'hFF00, 1'b1, 8'hFF, 8'h00, "R6");
    wait_done();
    issue(2'd1, 7'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, "R5");
    wait_done();
    issue(2'd2, 7'h00, 8'h00, 16'h0001, 1'b1, 8'h00, 8'h01, "R7");
    wait_done();
    repeat (10) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    summary();
  end
endmodule